// File: doc/BRIEF.md
# Real-Time Clock Calendar Register Block

This block keeps time of day and a calendar in a small byte-wide register file. A host writes and reads single bytes through a strobed port. Low addresses hold the time fields. Four status bytes sit above them and set the operating modes. A one-pulse-per-second strobe advances the calendar by one second. The carry runs through minutes, hours, weekday, day of month, month and a two-digit year.

Every time field is kept either as packed BCD or as plain binary, chosen by a mode bit. The periodic interrupt output follows a separate rate strobe while its enable bit is set. A freeze bit lets the host load a consistent time without the counter running underneath it.

Top module: `rtc_regfile`

## Requirements
- R1: On reset, status A reads as 0x26 with bit 7 clear. Status B holds 0x42, or 0x46 when `bin_mode_cfg` is 1. All time bytes are 0x00.
- R2: The ten bytes at addresses 0x00–0x09 are plain storage for host writes. A read started with `rd_en` returns its byte on `rdata` one clock later. The layout is: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day 0x07, month 0x08, year 0x09.
- R3: With status B bit 2 at 0, fields are packed BCD, tens digit in the high nibble. With bit 2 at 1, fields are plain binary. The calendar update reads and writes the stored bytes in the current mode.
- R4: Each `sec_tick` adds one second. Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0 and carry into the day.
- R5: A day carry moves the weekday 7→1, where 1 is Sunday, and otherwise adds 1. The day of month wraps to 1 past the month's length. The month wraps 12→1 and carries into the year. The year wraps 99→0.
- R6: February has 29 days when ((year+50) mod 100)+1950 is divisible by 4, and 28 days otherwise. April, June, September and November have 30 days. All other months have 31.
- R7: While status B bit 7 is 1, `sec_tick` is ignored and no time byte changes.
- R8: A write to status A (0x0A) stores bits 6:0 and leaves bit 7 unchanged. Each read of status A first inverts bit 7 and then returns the byte.
- R9: Status C (0x0B+1=0x0C), status D (0x0D) and addresses 0x0E–0x0F always read 0x00, and writes to them are ignored. Status B (0x0B) stores all eight written bits.
- R10: `irq` is high in exactly the cycles where `rate_tick` is high and status B bit 6 is 1. A write that clears bit 6 silences `irq` from the next cycle.
- R11: When a host write to a time byte coincides with `sec_tick`, that byte takes the written value. The other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_mode_cfg | input | 1 | Reset value of the binary-mode bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| sec_tick | input | 1 | One-second strobe |
| rate_tick | input | 1 | Periodic-rate strobe |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
Several properties are checked on every cycle:
- the seconds byte changes on every unfrozen tick and holds while frozen;
- status A keeps its top bit across writes;
- C and D read back zero;
- `irq` never appears without a rate strobe or after its enable is cleared.

The bench's scenarios cover the rest:
- full calendar rollover across the year boundary;
- leap and non-leap February ends in both BCD and binary;
- the alternating status A readback;
- the tick-versus-write collision.

A behavioural model compares `rdata` and `irq` on every clock.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int NTIME = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bin_mode_cfg,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          sec_tick,
  input  logic          rate_tick,
  output logic          irq
);
  localparam logic [AW-1:0] A_SEC  = AW'(0);
  localparam logic [AW-1:0] A_MIN  = AW'(2);
  localparam logic [AW-1:0] A_HR   = AW'(4);
  localparam logic [AW-1:0] A_WDAY = AW'(6);
  localparam logic [AW-1:0] A_MDAY = AW'(7);
  localparam logic [AW-1:0] A_MON  = AW'(8);
  localparam logic [AW-1:0] A_YR   = AW'(9);
  localparam logic [AW-1:0] A_STA  = AW'(NTIME);
  localparam logic [AW-1:0] A_STB  = AW'(NTIME + 1);
  localparam logic [DW-1:0] STA_RST = 8'h26;

  logic [DW-1:0] tf_q [NTIME];
  logic [DW-1:0] rega_q, regb_q;
  logic          bin;
  logic [DW-1:0] s, mi, h, wd, md, mo, y;
  logic [DW-1:0] s_n, mi_n, h_n, wd_n, md_n, mo_n, y_n;
  logic          c_min, c_hr, c_day, c_mon, c_yr, leap;
  logic [11:0]   wyear;
  logic [DW-1:0] dim, rd_byte;

  function automatic logic [DW-1:0] dec(input logic [DW-1:0] v, input logic b);
    return b ? v : ({4'd0, v[3:0]} + ({4'd0, v[7:4]} * 8'd10));
  endfunction

  function automatic logic [DW-1:0] enc(input logic [DW-1:0] v, input logic b);
    logic [DW-1:0] q, r;
    q = v / 8'd10;
    r = v % 8'd10;
    return b ? v : {q[3:0], r[3:0]};
  endfunction

  assign bin = regb_q[2];
  assign s   = dec(tf_q[A_SEC], bin);
  assign mi  = dec(tf_q[A_MIN], bin);
  assign h   = dec(tf_q[A_HR], bin);
  assign wd  = dec(tf_q[A_WDAY], bin);
  assign md  = dec(tf_q[A_MDAY], bin);
  assign mo  = dec(tf_q[A_MON], bin);
  assign y   = dec(tf_q[A_YR], bin);

  assign wyear = ((({4'd0, y} + 12'd50) % 12'd100) + 12'd1950);
  assign leap  = (wyear[1:0] == 2'b00);

  always_comb begin
    case (mo)
      8'd2:                     dim = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  dim = 8'd30;
      default:                  dim = 8'd31;
    endcase
  end

  assign c_min = (s >= 8'd59);
  assign c_hr  = c_min && (mi >= 8'd59);
  assign c_day = c_hr && (h >= 8'd23);
  assign c_mon = c_day && (md >= dim);
  assign c_yr  = c_mon && (mo >= 8'd12);

  assign s_n  = c_min ? 8'd0 : s + 8'd1;
  assign mi_n = !c_min ? mi : (c_hr ? 8'd0 : mi + 8'd1);
  assign h_n  = !c_hr ? h : (c_day ? 8'd0 : h + 8'd1);
  assign wd_n = !c_day ? wd : ((wd >= 8'd7) ? 8'd1 : wd + 8'd1);
  assign md_n = !c_day ? md : (c_mon ? 8'd1 : md + 8'd1);
  assign mo_n = !c_mon ? mo : (c_yr ? 8'd1 : mo + 8'd1);
  assign y_n  = !c_yr ? y : ((y >= 8'd99) ? 8'd0 : y + 8'd1);

  always_comb begin
    if (addr < A_STA)       rd_byte = tf_q[addr];
    else if (addr == A_STA) rd_byte = {~rega_q[7], rega_q[6:0]};
    else if (addr == A_STB) rd_byte = regb_q;
    else                    rd_byte = '0;
  end

  assign irq = rate_tick & regb_q[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTIME; i++) tf_q[i] <= '0;
      rega_q <= STA_RST;
      regb_q <= {5'b01000, bin_mode_cfg, 2'b10};
      rdata  <= '0;
    end else begin
      if (sec_tick && !regb_q[7]) begin
        tf_q[A_SEC]  <= enc(s_n, bin);
        tf_q[A_MIN]  <= enc(mi_n, bin);
        tf_q[A_HR]   <= enc(h_n, bin);
        tf_q[A_WDAY] <= enc(wd_n, bin);
        tf_q[A_MDAY] <= enc(md_n, bin);
        tf_q[A_MON]  <= enc(mo_n, bin);
        tf_q[A_YR]   <= enc(y_n, bin);
      end
      if (wr_en) begin
        if (addr < A_STA)       tf_q[addr] <= wdata;
        else if (addr == A_STA) rega_q <= {rega_q[7], wdata[6:0]};
        else if (addr == A_STB) regb_q <= wdata;
      end
      if (rd_en) begin
        rdata <= rd_byte;
        if (addr == A_STA) rega_q[7] <= ~rega_q[7];
      end
    end
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          sec_tick,
  input logic          rate_tick,
  input logic          irq,
  input logic [7:0]    rega,
  input logic [7:0]    regb,
  input logic [7:0]    secb
);
  assert_sec_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !regb[7] && !(wr_en && addr == AW'(0))) |=> (secb != $past(secb)));

  assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && regb[7] && !(wr_en && addr == AW'(0))) |=> $stable(secb));

  assert_uip_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == AW'(10)) |=>
      (rega[7] == $past(rega[7]) && rega[6:0] == $past(wdata[6:0])));

  assert_cd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == AW'(12) || addr == AW'(13))) |=> (rdata == 8'h00));

  assert_irq_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rate_tick);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(11) && !wdata[6]) |=> !irq);
endmodule

bind rtc_regfile rtc_regfile_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick), .rate_tick(rate_tick),
  .irq(irq), .rega(rega_q), .regb(regb_q), .secb(tf_q[0])
);

// File: tb/test_rtc_regfile.sv
`timescale 1ns/1ps
module test_rtc_regfile;
  logic clk = 1'b0, rst_n = 1'b0, bin_mode_cfg = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, sec_tick = 1'b0, rate_tick = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  rtc_regfile i_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .bin_mode_cfg(bin_mode_cfg), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sec_tick(sec_tick), .rate_tick(rate_tick), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int m_tf [10];
  int m_a, m_b, m_rd;

  function automatic int dcd(int v, bit b);
    return b ? v : ((v >> 4) * 10 + (v & 15));
  endfunction
  function automatic int ecd(int v, bit b);
    return b ? v : (((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int mdays(int mon, int yy);
    int full;
    full = ((yy + 50) % 100) + 1950;
    if (mon == 2) return (full % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    bit b;
    int sc, mn, hr, wk, dy, mo, yr;
    b = m_b[2];
    sc = dcd(m_tf[0], b); mn = dcd(m_tf[2], b); hr = dcd(m_tf[4], b);
    wk = dcd(m_tf[6], b); dy = dcd(m_tf[7], b); mo = dcd(m_tf[8], b);
    yr = dcd(m_tf[9], b);
    sc++;
    if (sc >= 60) begin
      sc = 0; mn++;
      if (mn >= 60) begin
        mn = 0; hr++;
        if (hr >= 24) begin
          hr = 0;
          wk = (wk >= 7) ? 1 : wk + 1;
          if (dy >= mdays(mo, yr)) begin
            dy = 1;
            if (mo >= 12) begin mo = 1; yr = (yr >= 99) ? 0 : yr + 1; end
            else mo++;
          end else dy++;
        end
      end
    end
    m_tf[0] = ecd(sc, b); m_tf[2] = ecd(mn, b); m_tf[4] = ecd(hr, b);
    m_tf[6] = ecd(wk, b); m_tf[7] = ecd(dy, b); m_tf[8] = ecd(mo, b);
    m_tf[9] = ecd(yr, b);
  endtask

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    int rv;
    if (!rst_n) begin
      foreach (m_tf[i]) m_tf[i] = 0;
      m_a = 8'h26; m_b = 8'h42 | (bin_mode_cfg ? 8'h04 : 8'h00); m_rd = 0;
    end else begin
      if (addr < 10) rv = m_tf[addr];
      else if (addr == 10) rv = m_a ^ 8'h80;
      else if (addr == 11) rv = m_b;
      else rv = 0;
      if (sec_tick && !m_b[7]) model_tick();
      if (wr_en) begin
        if (addr < 10) m_tf[addr] = wdata;
        else if (addr == 10) m_a = (m_a & 8'h80) | (wdata & 8'h7F);
        else if (addr == 11) m_b = wdata;
      end
      if (rd_en) begin
        m_rd = rv;
        if (addr == 10) m_a = m_a ^ 8'h80;
      end
    end
    #1;
    chk({cur_req, " rdata"}, rdata, m_rd);
    chk({cur_req, " irq"}, irq, rate_tick && m_b[6]);
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd_chk(int a, int exp, string req);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); rd_en = 1'b0;
    chk(req, rdata, exp);
  endtask
  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask
  task automatic set_time(int sc, int mn, int hr, int wk, int dy, int mo, int yr);
    wr(0, sc); wr(2, mn); wr(4, hr); wr(6, wk); wr(7, dy); wr(8, mo); wr(9, yr);
  endtask
  task automatic do_reset(bit cfg);
    @(negedge clk); rst_n = 1'b0; bin_mode_cfg = cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cur_req = "R1";
    do_reset(1'b0);
    rd_chk(10, 8'hA6, "R1 R8 status A first read");
    rd_chk(10, 8'h26, "R8 status A second read");
    rd_chk(11, 8'h42, "R1 status B bcd cfg");
    rd_chk(0, 8'h00, "R1 seconds reset");

    cur_req = "R2";
    wr(1, 8'h5A); wr(9, 8'h37);
    rd_chk(1, 8'h5A, "R2 storage byte");
    rd_chk(9, 8'h37, "R2 year byte");

    cur_req = "R9";
    wr(12, 8'hFF); wr(13, 8'h11);
    rd_chk(12, 8'h00, "R9 status C");
    rd_chk(13, 8'h00, "R9 status D");
    rd_chk(14, 8'h00, "R9 unmapped");

    cur_req = "R8";
    wr(10, 8'hFF);
    rd_chk(10, 8'hFF, "R8 after write read 1");
    rd_chk(10, 8'h7F, "R8 after write read 2");
    wr(10, 8'h26);

    cur_req = "R5";
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick();
    rd_chk(0, 8'h00, "R4 sec wrap");
    rd_chk(2, 8'h00, "R4 min wrap");
    rd_chk(4, 8'h00, "R4 hour wrap");
    rd_chk(6, 8'h01, "R5 weekday wrap");
    rd_chk(7, 8'h01, "R5 mday wrap");
    rd_chk(8, 8'h01, "R5 month wrap");
    rd_chk(9, 8'h00, "R5 year wrap");

    cur_req = "R3";
    wr(0, 8'h09); tick();
    rd_chk(0, 8'h10, "R3 bcd digit carry");

    cur_req = "R6";
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    tick();
    rd_chk(7, 8'h29, "R6 leap feb 29");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    tick();
    rd_chk(7, 8'h01, "R6 leap end day");
    rd_chk(8, 8'h03, "R6 leap end month");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h50);
    tick();
    rd_chk(8, 8'h03, "R6 1950 not leap");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h10);
    tick();
    rd_chk(8, 8'h05, "R6 april 30 days");

    cur_req = "R11";
    wr(0, 8'h20);
    @(negedge clk); wr_en = 1'b1; addr = 4'd0; wdata = 8'h30; sec_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; sec_tick = 1'b0;
    rd_chk(0, 8'h30, "R11 write beats tick");

    cur_req = "R7";
    wr(11, 8'hC2);
    tick(); tick();
    rd_chk(0, 8'h30, "R7 frozen seconds");
    wr(11, 8'h42);
    tick();
    rd_chk(0, 8'h31, "R7 unfrozen seconds");

    cur_req = "R3";
    wr(11, 8'h46);
    set_time(59, 59, 23, 2, 30, 4, 5);
    tick();
    rd_chk(7, 8'h01, "R3 binary mday");
    rd_chk(8, 8'h05, "R3 binary month");
    wr(0, 9); tick();
    rd_chk(0, 8'h0A, "R3 binary seconds");

    cur_req = "R10";
    @(negedge clk); rate_tick = 1'b1; #1;
    chk("R10 irq on", irq, 1);
    @(negedge clk); rate_tick = 1'b0; #1;
    chk("R10 irq idle", irq, 0);
    @(negedge clk); wr_en = 1'b1; addr = 4'd11; wdata = 8'h06; rate_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R10 irq stopped", irq, 0);
    @(negedge clk); rate_tick = 1'b0;
    wr(11, 8'h46);
    @(negedge clk); rate_tick = 1'b1; #1;
    chk("R10 irq restarted", irq, 1);
    @(negedge clk); rate_tick = 1'b0;

    cur_req = "R1";
    do_reset(1'b1);
    rd_chk(11, 8'h46, "R1 status B binary cfg");
    rd_chk(8, 8'h00, "R1 month reset");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule